// File: doc/BRIEF.md
# Serial Flash Protocol-Mode and Program-Accelerator Controller

This block holds the volatile configuration state of a serial NOR flash. One 8-bit configuration write selects the active I/O protocol (extended single-line, dual or quad), turns the hold/reset function of the shared data-3 pin off or on, permits or forbids the high-voltage program accelerator, and sets the output driver strength. The hold setting and the driver strength take their power-on values from a non-volatile configuration word. The block drives the effective protocol, the hold enable and the strength code to the rest of the device.

The accelerator is permitted when configuration bit 3 is 0. A quad modify command followed by deselect then opens a timed window for the accelerator pin to reach the high level. If the pin reaches the high level inside the window, the operation runs fast. If the window closes first, the operation runs at normal speed and a sticky error flag is set, which stays set until a clear strobe arrives. If the device was in quad protocol when the command arrived, it falls back to extended protocol during the operation so that status polling and suspend still work. It stays there until the accelerator pin has returned low.

Top module: `flash_mode_ctrl`

## Requirements
- R1: The effective protocol code is 2 (quad) when write bit 7 is 0, whatever bit 6 is. It is 1 (dual) when bit 7 is 1 and bit 6 is 0. It is 0 (extended) when both bits are 1. After reset both bits are 1.
- R2: A configuration write takes effect only on a write strobe while chip select `cs_n` is high (deselected). A strobe while `cs_n` is low changes no output.
- R3: After reset, `hold_en` equals bit 0 of `nv_hold_on`, `drv_strength` equals `nv_drv`, and the accelerator is forbidden (bit 3 = 1).
- R4: `hold_en` equals written bit 4, and `drv_strength` equals written bits 2:0, from the cycle after an accepted write.
- R5: With bit 3 = 1, modify commands leave the protocol unchanged and never raise `fast_modify` or the error flag, even when the accelerator pin is high.
- R6: With bit 3 = 0 and quad protocol active, a quad program or an erase followed by deselect makes the protocol read 0 (extended). It returns to quad only in the cycle after the accelerator pin falls from high, or when the window expires.
- R7: If the accelerator pin is high during the window, `fast_modify` is 1 from the next cycle and stays 1 while the pin stays high. The error flag is not set.
- R8: Counting from the cycle in which the window opens (two clock edges after the command strobe when deselect follows the strobe at once), the error flag is set at the WINDOW_CYC-th edge of the window if the pin never rose. The effective protocol returns to the configured one at that same edge.
- R9: The error flag stays at 1 until `clr_flag` is seen. If the flag is being set and cleared in the same cycle, setting wins.
- R10: In dual or extended protocol, an accelerated quad program still opens the window but leaves the protocol unchanged. An erase outside quad protocol is not a quad modify and opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| nv_hold_on | input | 1 | Non-volatile power-on value of hold enable (1 = enabled) |
| nv_drv | input | 3 | Non-volatile power-on driver strength code |
| cs_n | input | 1 | Chip select, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cmd_qprog | input | 1 | Quad page program received with all data |
| cmd_erase | input | 1 | Erase command received |
| vpp_high | input | 1 | Accelerator pin is at the high level |
| clr_flag | input | 1 | Clear-flag-status strobe |
| proto_mode | output | 2 | Effective protocol: 0 extended, 1 dual, 2 quad |
| hold_en | output | 1 | Hold/reset function of data-3 pin enabled |
| drv_strength | output | 3 | Output driver strength code |
| fast_modify | output | 1 | Modify operation running accelerated |
| flag_vpp_err | output | 1 | Sticky accelerator-timeout error flag |

## Verification
Two events can land on the same edge: the window expiring, which sets the error flag, and a clear-flag strobe from software. The bench first leaves the flag set by an earlier timeout. It then starts a second window and pulses `clr_flag` on exactly the expiry edge, and it expects the flag to read 1 afterwards. A plain clear is then applied to show that the flag drops when no set competes with it.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
  typedef enum logic [1:0] {
    PROTO_EXT  = 2'd0,
    PROTO_DUAL = 2'd1,
    PROTO_QUAD = 2'd2
  } proto_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_FAST  = 2'd3
  } seq_e;

  typedef struct packed {
    logic       quad_n;
    logic       dual_n;
    logic       hold_on;
    logic       acc_off;
    logic [2:0] drv;
  } vcfg_t;
endpackage

// File: rtl/fmc_cfg_reg.sv
module fmc_cfg_reg
  import flash_mode_pkg::*;
#(
  parameter int DRV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_hold_on,
  input  logic [DRV_W-1:0] nv_drv,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output vcfg_t            cfg,
  output proto_e           base_proto
);
  vcfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.quad_n  = wdata[7];
      cfg_d.dual_n  = wdata[6];
      cfg_d.hold_on = wdata[4];
      cfg_d.acc_off = wdata[3];
      cfg_d.drv     = wdata[DRV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.quad_n  <= 1'b1;
      cfg_q.dual_n  <= 1'b1;
      cfg_q.hold_on <= nv_hold_on;
      cfg_q.acc_off <= 1'b1;
      cfg_q.drv     <= nv_drv;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    if (!cfg_q.quad_n)      base_proto = PROTO_QUAD;
    else if (!cfg_q.dual_n) base_proto = PROTO_DUAL;
    else                    base_proto = PROTO_EXT;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/fmc_accel_seq.sv
module fmc_accel_seq
  import flash_mode_pkg::*;
#(
  parameter int WINDOW_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_en,
  input  logic base_quad,
  input  logic quad_mod,
  input  logic cs_n,
  input  logic vpp_high,
  output logic fast,
  output logic force_ext,
  output logic expire
);
  localparam int CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

  seq_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drop_q, drop_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drop_d  = drop_q;
    expire  = 1'b0;
    case (state_q)
      SEQ_IDLE: if (acc_en && quad_mod) begin
        state_d = SEQ_ARMED;
        drop_d  = base_quad;
      end
      SEQ_ARMED: if (cs_n) begin
        state_d = SEQ_WAIT;
        cnt_d   = '0;
      end
      SEQ_WAIT: begin
        if (vpp_high) begin
          state_d = SEQ_FAST;
        end else if (cnt_q == LAST) begin
          state_d = SEQ_IDLE;
          expire  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_FAST: if (!vpp_high) state_d = SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drop_q  <= drop_d;
    end
  end

  assign fast      = (state_q == SEQ_FAST);
  assign force_ext = drop_q && ((state_q == SEQ_WAIT) || (state_q == SEQ_FAST));
endmodule

// File: rtl/fmc_err_flag.sv
module fmc_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int WINDOW_MS  = 200,
  parameter int WINDOW_CYC = (CLK_HZ / 1000) * WINDOW_MS,
  parameter int DRV_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_hold_on,
  input  logic [DRV_W-1:0] nv_drv,
  input  logic             cs_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  input  logic             cmd_qprog,
  input  logic             cmd_erase,
  input  logic             vpp_high,
  input  logic             clr_flag,
  output logic [1:0]       proto_mode,
  output logic             hold_en,
  output logic [DRV_W-1:0] drv_strength,
  output logic             fast_modify,
  output logic             flag_vpp_err
);
  logic   rst_meta, rst_sync;
  vcfg_t  cfg;
  proto_e base_proto;
  logic   wr_en, quad_mod, seq_fast, seq_force, seq_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign wr_en    = cfg_wr & cs_n;
  assign quad_mod = cmd_qprog | (cmd_erase & (base_proto == PROTO_QUAD));

  fmc_cfg_reg #(.DRV_W(DRV_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync),
    .nv_hold_on (nv_hold_on),
    .nv_drv     (nv_drv),
    .wr_en      (wr_en),
    .wdata      (cfg_wdata),
    .cfg        (cfg),
    .base_proto (base_proto)
  );

  fmc_accel_seq #(.WINDOW_CYC(WINDOW_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .acc_en    (~cfg.acc_off),
    .base_quad (base_proto == PROTO_QUAD),
    .quad_mod  (quad_mod),
    .cs_n      (cs_n),
    .vpp_high  (vpp_high),
    .fast      (seq_fast),
    .force_ext (seq_force),
    .expire    (seq_expire)
  );

  fmc_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_sync),
    .set   (seq_expire),
    .clr   (clr_flag),
    .flag  (flag_vpp_err)
  );

  assign proto_mode   = seq_force ? PROTO_EXT : base_proto;
  assign hold_en      = cfg.hold_on;
  assign drv_strength = cfg.drv;
  assign fast_modify  = seq_fast;
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker #(
  parameter int DRV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cfg_wr,
  input logic             vpp_high,
  input logic             clr_flag,
  input logic [1:0]       proto_mode,
  input logic             hold_en,
  input logic [DRV_W-1:0] drv_strength,
  input logic             fast_modify,
  input logic             flag_vpp_err
);
  assert_proto_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    proto_mode != 2'd3);

  assert_no_write_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cs_n) |=> ($stable(hold_en) && $stable(drv_strength)));

  assert_fast_needs_vpp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_modify) |-> $past(vpp_high));

  assert_fast_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_modify && !vpp_high) |=> !fast_modify);

  assert_err_only_without_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_vpp_err) |-> $past(!vpp_high));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vpp_err && !clr_flag) |=> flag_vpp_err);
endmodule

bind flash_mode_ctrl fmc_checker #(.DRV_W(DRV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .cfg_wr       (cfg_wr),
  .vpp_high     (vpp_high),
  .clr_flag     (clr_flag),
  .proto_mode   (proto_mode),
  .hold_en      (hold_en),
  .drv_strength (drv_strength),
  .fast_modify  (fast_modify),
  .flag_vpp_err (flag_vpp_err)
);

// File: tb/sim_flash_mode_ctrl.sv
`timescale 1ns/1ps
module sim_flash_mode_ctrl;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_hold_on = 1'b1;
  logic [2:0] nv_drv = 3'd0;
  logic       cs_n = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       cmd_qprog = 1'b0;
  logic       cmd_erase = 1'b0;
  logic       vpp_high = 1'b0;
  logic       clr_flag = 1'b0;
  logic [1:0] proto_mode;
  logic       hold_en;
  logic [2:0] drv_strength;
  logic       fast_modify;
  logic       flag_vpp_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  flash_mode_ctrl #(.WINDOW_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .nv_hold_on(nv_hold_on), .nv_drv(nv_drv),
    .cs_n(cs_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cmd_qprog(cmd_qprog), .cmd_erase(cmd_erase), .vpp_high(vpp_high),
    .clr_flag(clr_flag), .proto_mode(proto_mode), .hold_en(hold_en),
    .drv_strength(drv_strength), .fast_modify(fast_modify),
    .flag_vpp_err(flag_vpp_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_proto(input logic [7:0] v);
    if (!v[7])      return 2;
    else if (!v[6]) return 1;
    else            return 0;
  endfunction

  task automatic do_reset(input logic h, input logic [2:0] d);
    @(negedge clk);
    rst_n = 1'b0; nv_hold_on = h; nv_drv = d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b1; cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Strobe a command while selected, deselect, and return one edge later (window open).
  task automatic issue(input logic prog, input logic ers);
    @(negedge clk);
    cs_n = 1'b0; cmd_qprog = prog; cmd_erase = ers;
    @(negedge clk);
    cmd_qprog = 1'b0; cmd_erase = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R3: reset values for every non-volatile combination
    for (int h = 0; h < 2; h++) begin
      for (int d = 0; d < 8; d++) begin
        do_reset(h[0], d[2:0]);
        chk("R3 hold", int'(hold_en), h);
        chk("R3 drv", int'(drv_strength), d);
        chk("R1 reset proto", int'(proto_mode), 0);
        chk("R3 err", int'(flag_vpp_err), 0);
      end
    end
    // R3: accelerator forbidden after reset -> quad program does nothing
    do_reset(1'b1, 3'd5);
    issue(1'b1, 1'b0);
    repeat (W + 2) @(negedge clk);
    chk("R3 acc off", int'(flag_vpp_err), 0);

    // R1/R4: sweep every write value
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R1 proto", int'(proto_mode), exp_proto(v[7:0]));
      chk("R4 hold", int'(hold_en), int'(v[4]));
      chk("R4 drv", int'(drv_strength), v % 8);
    end

    // R2: write while selected is ignored
    wr(8'hD3);
    @(negedge clk);
    cs_n = 1'b0; cfg_wr = 1'b1; cfg_wdata = 8'h04;
    @(negedge clk);
    cfg_wr = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    chk("R2 hold", int'(hold_en), 1);
    chk("R2 drv", int'(drv_strength), 3);
    chk("R2 proto", int'(proto_mode), 0);

    // R6/R8: quad, accelerator permitted, window expires
    wr(8'h55);
    issue(1'b1, 1'b0);
    chk("R6 drop to ext", int'(proto_mode), 0);
    repeat (W - 1) @(negedge clk);
    chk("R8 no err before end", int'(flag_vpp_err), 0);
    chk("R6 still ext", int'(proto_mode), 0);
    @(negedge clk);
    chk("R8 err at end", int'(flag_vpp_err), 1);
    chk("R8 proto back", int'(proto_mode), 2);
    chk("R8 not fast", int'(fast_modify), 0);
    repeat (5) @(negedge clk);
    chk("R9 sticky", int'(flag_vpp_err), 1);

    // R9: set and clear on the same edge -> set wins
    issue(1'b1, 1'b0);
    repeat (W - 1) @(negedge clk);
    pulse_clr();
    chk("R9 set wins", int'(flag_vpp_err), 1);
    pulse_clr();
    chk("R9 cleared", int'(flag_vpp_err), 0);

    // R6/R7: quad erase accelerated
    issue(1'b0, 1'b1);
    chk("R6 erase drop", int'(proto_mode), 0);
    @(negedge clk);
    vpp_high = 1'b1;
    @(negedge clk);
    chk("R7 fast on", int'(fast_modify), 1);
    repeat (2 * W) @(negedge clk);
    chk("R7 fast held", int'(fast_modify), 1);
    chk("R7 no err", int'(flag_vpp_err), 0);
    chk("R6 ext while high", int'(proto_mode), 0);
    vpp_high = 1'b0;
    @(negedge clk);
    chk("R7 fast off", int'(fast_modify), 0);
    chk("R6 quad back", int'(proto_mode), 2);

    // R5: accelerator forbidden in quad
    wr(8'h5D);
    issue(1'b1, 1'b0);
    chk("R5 proto kept", int'(proto_mode), 2);
    vpp_high = 1'b1;
    repeat (W + 2) @(negedge clk);
    chk("R5 no fast", int'(fast_modify), 0);
    vpp_high = 1'b0;
    repeat (W) @(negedge clk);
    chk("R5 no err", int'(flag_vpp_err), 0);

    // R10: dual protocol, accelerated program, window expires
    wr(8'hB2);
    issue(1'b1, 1'b0);
    chk("R10 dual kept", int'(proto_mode), 1);
    repeat (W) @(negedge clk);
    chk("R10 err", int'(flag_vpp_err), 1);
    chk("R10 dual after", int'(proto_mode), 1);
    pulse_clr();

    // R10: extended protocol, erase is not a quad modify
    wr(8'hF0);
    issue(1'b0, 1'b1);
    repeat (W + 2) @(negedge clk);
    chk("R10 ext erase", int'(flag_vpp_err), 0);
    chk("R10 ext proto", int'(proto_mode), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule